// File: doc/BRIEF.md
# Dual-Channel Tick-Driven PWM Controller

This block generates two independent pulse-width-modulated pin signals. Each channel has an 8-bit counter. The counter does not step on the system clock. It steps only when that channel's external variable-frequency generator presents a one-cycle tick. The counter is compared against a programmed high-time and a programmed period, so the waveform has a period of `PERIOD+1` ticks and stays high for the first `ON` ticks of each period.

A small memory-mapped register file holds the settings. Each channel has a mode nibble with four bits: run, output-off, force-high and open-drain. A route bit per channel picks whether the pin shows the PWM waveform or the raw generator waveform. Two control-word bytes per channel are stored for the generator. An output stage per channel turns the selected level into a pin value and a pin-enable pair, either push-pull or open-drain.

Changes to high-time and period are held in staging registers while a channel runs. They are copied into the working registers only at a period boundary, so a waveform never changes shape partway through a period.

Top module: `twin_pwm_ctrl`

## Requirements
- R1: After reset every register reads zero, and each pin is driven (pin_oe=1) with pin_out equal to that channel's raw wave input.
- R2: Byte addresses decode as follows, with ch in 0..1. The mode register is at 0x00, holding nibble ch at bits [4ch+3:4ch]. The route register is at 0x04, holding bit 4ch. The control-word high byte is at 0x08+8ch and the low byte at 0x0C+8ch. The high-time is at 0x18+8ch and the period at 0x1C+8ch. Each of these four per-channel registers is 8 bits. Reads return the written values. Unimplemented bits and unmapped addresses read zero.
- R3: With run (mode bit 0) set and route bit set, the counter advances by one only on a cycle where the channel's tick is high. It wraps to 0 on the tick that finds it at or above the period. The pin is high while the count is below the high-time, giving ON high ticks in each PERIOD+1 ticks.
- R4: A high-time greater than the period gives a steady high level. High-time 0xFF with period 0xFE gives a constant high.
- R5: While run is clear the counter is held at 0 and the PWM level is low.
- R6: With the route bit clear, the selected level is the raw wave input.
- R7: Force-high (mode bit 2) makes the selected level high whatever the counter or route.
- R8: Output-off (mode bit 1) makes pin_oe=0 and pin_out=0, overriding force-high and open-drain.
- R9: With open-drain (mode bit 3) and output-off clear, pin_out is 0 and pin_oe is the inverse of the selected level.
- R10: While a channel runs, new high-time or period values take effect only after the next wrap. While it is stopped they are taken up at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| vf_tick | input | 2 | Per-channel one-cycle tick from the variable-frequency generator |
| vf_wave | input | 2 | Per-channel raw variable-frequency waveform |
| pin_out | output | 2 | Per-channel pin data |
| pin_oe | output | 2 | Per-channel pin drive enable |

## Verification
The bench targets the 100% duty setting, where high-time is 0xFF and period is 0xFE. A design that compared with less-or-equal, or that wrapped one count late, would let a low pulse appear once per period. It also rewrites the high-time in the middle of a running period. A design without staging would change the level before the wrap, and a design that never reloaded would keep the old duty afterwards. Stopping a channel must clear the count. A design that only paused would resume mid-period and shift every later edge. Priority checks pair output-off with force-high and open-drain with force-high, to catch a design that drives the pin actively when it should release it. Random mode, route, timing and tick traffic are compared each cycle against a bench model, including cycles without ticks that must leave the counter unchanged.

// File: rtl/twin_pwm_pkg.sv
package twin_pwm_pkg;

  // Per-channel mode nibble; bit 0 is run, bit 1 output-off, bit 2 force-high, bit 3 open-drain.
  typedef struct packed {
    logic opendrain;
    logic force_hi;
    logic out_off;
    logic run;
  } ch_mode_t;

  localparam int FIELD_W   = 4;
  localparam int MODE_OFS  = 'h00;
  localparam int ROUTE_OFS = 'h04;
  localparam int CWH_OFS   = 'h08;
  localparam int CWL_OFS   = 'h0C;
  localparam int ON_OFS    = 'h18;
  localparam int PER_OFS   = 'h1C;
  localparam int CH_STRIDE = 8;

endpackage

// File: rtl/twin_pwm_rst_sync.sv
module twin_pwm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/twin_pwm_regs.sv
module twin_pwm_regs
  import twin_pwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 8,
  parameter int CW_W   = 8,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wdata,
  output logic [DATA_W-1:0]                 rdata,
  output ch_mode_t [NUM_CH-1:0]             mode_q,
  output logic [NUM_CH-1:0]                 route_q,
  output logic [NUM_CH-1:0][CNT_W-1:0]      on_q,
  output logic [NUM_CH-1:0][CNT_W-1:0]      per_q
);

  ch_mode_t [NUM_CH-1:0]            mode_d;
  logic [NUM_CH-1:0]                route_d;
  logic [NUM_CH-1:0][CNT_W-1:0]     on_d, per_d;
  logic [NUM_CH-1:0][CW_W-1:0]      cwh_q, cwh_d, cwl_q, cwl_d;

  // Next-state: apply a single write
  always_comb begin
    mode_d  = mode_q;
    route_d = route_q;
    on_d    = on_q;
    per_d   = per_q;
    cwh_d   = cwh_q;
    cwl_d   = cwl_q;
    if (wr_en) begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (addr == ADDR_W'(MODE_OFS))
          mode_d[ch] = ch_mode_t'(wdata[FIELD_W*ch +: FIELD_W]);
        if (addr == ADDR_W'(ROUTE_OFS))
          route_d[ch] = wdata[FIELD_W*ch];
        if (addr == ADDR_W'(CWH_OFS + CH_STRIDE*ch)) cwh_d[ch] = wdata[CW_W-1:0];
        if (addr == ADDR_W'(CWL_OFS + CH_STRIDE*ch)) cwl_d[ch] = wdata[CW_W-1:0];
        if (addr == ADDR_W'(ON_OFS  + CH_STRIDE*ch)) on_d[ch]  = wdata[CNT_W-1:0];
        if (addr == ADDR_W'(PER_OFS + CH_STRIDE*ch)) per_d[ch] = wdata[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      route_q <= '0;
      on_q    <= '0;
      per_q   <= '0;
      cwh_q   <= '0;
      cwl_q   <= '0;
    end else if (wr_en) begin
      mode_q  <= mode_d;
      route_q <= route_d;
      on_q    <= on_d;
      per_q   <= per_d;
      cwh_q   <= cwh_d;
      cwl_q   <= cwl_d;
    end
  end

  // Read mux; unmapped addresses return zero
  always_comb begin
    rdata = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (addr == ADDR_W'(MODE_OFS))
        rdata[FIELD_W*ch +: FIELD_W] = mode_q[ch];
      if (addr == ADDR_W'(ROUTE_OFS))
        rdata[FIELD_W*ch] = route_q[ch];
      if (addr == ADDR_W'(CWH_OFS + CH_STRIDE*ch)) rdata[CW_W-1:0]  = cwh_q[ch];
      if (addr == ADDR_W'(CWL_OFS + CH_STRIDE*ch)) rdata[CW_W-1:0]  = cwl_q[ch];
      if (addr == ADDR_W'(ON_OFS  + CH_STRIDE*ch)) rdata[CNT_W-1:0] = on_q[ch];
      if (addr == ADDR_W'(PER_OFS + CH_STRIDE*ch)) rdata[CNT_W-1:0] = per_q[ch];
    end
  end

endmodule

// File: rtl/twin_pwm_channel.sv
module twin_pwm_channel #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] on_stage,
  input  logic [CNT_W-1:0] per_stage,
  output logic [CNT_W-1:0] cnt,
  output logic             pwm_lvl
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] on_q, on_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic             cnt_en;
  logic             wrap;

  assign cnt_en = !run || tick;
  assign wrap   = cnt_q >= per_q;

  always_comb begin
    cnt_d = cnt_q;
    on_d  = on_q;
    per_d = per_q;
    if (!run || wrap) begin
      cnt_d = '0;
      on_d  = on_stage;
      per_d = per_stage;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      on_q  <= '0;
      per_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      on_q  <= on_d;
      per_q <= per_d;
    end
  end

  assign cnt     = cnt_q;
  assign pwm_lvl = run && (cnt_q < on_q);

endmodule

// File: rtl/twin_pwm_pad_drv.sv
module twin_pwm_pad_drv
  import twin_pwm_pkg::*;
(
  input  ch_mode_t mode,
  input  logic     route_pwm,
  input  logic     pwm_lvl,
  input  logic     raw_wave,
  output logic     pin_out,
  output logic     pin_oe
);

  logic lvl;

  always_comb begin
    if (mode.force_hi)  lvl = 1'b1;
    else if (route_pwm) lvl = pwm_lvl;
    else                lvl = raw_wave;

    if (mode.out_off) begin
      pin_out = 1'b0;
      pin_oe  = 1'b0;
    end else if (mode.opendrain) begin
      pin_out = 1'b0;
      pin_oe  = !lvl;
    end else begin
      pin_out = lvl;
      pin_oe  = 1'b1;
    end
  end

endmodule

// File: rtl/twin_pwm_ctrl.sv
module twin_pwm_ctrl
  import twin_pwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 8,
  parameter int CW_W   = 8,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_CH-1:0] vf_tick,
  input  logic [NUM_CH-1:0] vf_wave,
  output logic [NUM_CH-1:0] pin_out,
  output logic [NUM_CH-1:0] pin_oe
);

  logic                          rst_sync_n;
  ch_mode_t [NUM_CH-1:0]         mode_q;
  logic [NUM_CH-1:0]             route_q;
  logic [NUM_CH-1:0][CNT_W-1:0]  on_q, per_q, ch_cnt;
  logic [NUM_CH-1:0]             pwm_lvl;

  twin_pwm_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  twin_pwm_regs #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .CW_W   (CW_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .mode_q  (mode_q),
    .route_q (route_q),
    .on_q    (on_q),
    .per_q   (per_q)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    twin_pwm_channel #(.CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .run       (mode_q[g].run),
      .tick      (vf_tick[g]),
      .on_stage  (on_q[g]),
      .per_stage (per_q[g]),
      .cnt       (ch_cnt[g]),
      .pwm_lvl   (pwm_lvl[g])
    );

    twin_pwm_pad_drv u_pad (
      .mode      (mode_q[g]),
      .route_pwm (route_q[g]),
      .pwm_lvl   (pwm_lvl[g]),
      .raw_wave  (vf_wave[g]),
      .pin_out   (pin_out[g]),
      .pin_oe    (pin_oe[g])
    );
  end

endmodule

// File: rtl/twin_pwm_chk.sv
module twin_pwm_chk
  import twin_pwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input ch_mode_t [NUM_CH-1:0]        mode,
  input logic [NUM_CH-1:0]            tick,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt,
  input logic [NUM_CH-1:0]            pin_out,
  input logic [NUM_CH-1:0]            pin_oe
);

  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R8
    a_r8_off_releases: assert property (@(posedge clk) disable iff (!rst_n)
      mode[g].out_off |-> (!pin_oe[g] && !pin_out[g]));
    // R9
    a_r9_od_never_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode[g].out_off && mode[g].opendrain) |-> !pin_out[g]);
    // R7
    a_r7_force_push_pull_high: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode[g].out_off && !mode[g].opendrain && mode[g].force_hi) |-> (pin_out[g] && pin_oe[g]));
    // R5
    a_r5_stop_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(!mode[g].run)) |-> (cnt[g] == '0));
    // R3
    a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(mode[g].run) && !$past(tick[g])) |-> (cnt[g] == $past(cnt[g])));
  end

endmodule

bind twin_pwm_ctrl twin_pwm_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .mode    (mode_q),
  .tick    (vf_tick),
  .cnt     (ch_cnt),
  .pin_out (pin_out),
  .pin_oe  (pin_oe)
);

// File: tb/twin_pwm_ctrl_test.sv
module twin_pwm_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [1:0]  vf_tick;
  logic [1:0]  vf_wave;
  logic [1:0]  pin_out;
  logic [1:0]  pin_oe;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  // bench model
  logic [3:0] m_mode [2];
  logic       m_route[2];
  logic [7:0] m_on[2], m_per[2], m_cwh[2], m_cwl[2];
  logic [7:0] a_cnt[2], a_on[2], a_per[2];

  always #2 clk = ~clk;

  twin_pwm_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vf_tick(vf_tick),
    .vf_wave(vf_wave), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [5:0] a);
    logic [31:0] r = '0;
    if (a == 6'h00) r = {24'h0, m_mode[1], m_mode[0]};
    if (a == 6'h04) r = {27'h0, m_route[1], 3'b000, m_route[0]};
    for (int c = 0; c < 2; c++) begin
      if (a == 6'(8'h08 + 8*c)) r = {24'h0, m_cwh[c]};
      if (a == 6'(8'h0C + 8*c)) r = {24'h0, m_cwl[c]};
      if (a == 6'(8'h18 + 8*c)) r = {24'h0, m_on[c]};
      if (a == 6'(8'h1C + 8*c)) r = {24'h0, m_per[c]};
    end
    return r;
  endfunction

  function automatic logic exp_lvl(input int c);
    if (m_mode[c][2]) return 1'b1;
    if (m_route[c])   return m_mode[c][0] && (a_cnt[c] < a_on[c]);
    return vf_wave[c];
  endfunction

  task automatic check_pins();
    for (int c = 0; c < 2; c++) begin
      logic eo, ee, l;
      string tag;
      l = exp_lvl(c);
      if (m_mode[c][1])      begin eo = 0; ee = 0;  tag = "R8"; end
      else if (m_mode[c][3]) begin eo = 0; ee = !l; tag = "R9"; end
      else                   begin eo = l; ee = 1;
        tag = m_mode[c][2] ? "R7" : (!m_route[c] ? "R6" : "R3"); end
      check({pin_out[c], pin_oe[c]} == {eo, ee}, tag,
            {pin_out[c], pin_oe[c]}, {eo, ee});
    end
  endtask

  task automatic model_edge(input bit we, input logic [5:0] a, input logic [31:0] d,
                            input logic [1:0] tk);
    for (int c = 0; c < 2; c++) begin
      if (!m_mode[c][0]) begin
        a_cnt[c] = 0; a_on[c] = m_on[c]; a_per[c] = m_per[c];
      end else if (tk[c]) begin
        if (a_cnt[c] >= a_per[c]) begin
          a_cnt[c] = 0; a_on[c] = m_on[c]; a_per[c] = m_per[c];
        end else a_cnt[c] = a_cnt[c] + 1;
      end
    end
    if (we) begin
      if (a == 6'h00) begin m_mode[0] = d[3:0]; m_mode[1] = d[7:4]; end
      if (a == 6'h04) begin m_route[0] = d[0]; m_route[1] = d[4]; end
      for (int c = 0; c < 2; c++) begin
        if (a == 6'(8'h08 + 8*c)) m_cwh[c] = d[7:0];
        if (a == 6'(8'h0C + 8*c)) m_cwl[c] = d[7:0];
        if (a == 6'(8'h18 + 8*c)) m_on[c]  = d[7:0];
        if (a == 6'(8'h1C + 8*c)) m_per[c] = d[7:0];
      end
    end
  endtask

  task automatic step(input bit we, input logic [5:0] a, input logic [31:0] d,
                      input logic [1:0] tk, input logic [1:0] wv);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d; vf_tick = tk; vf_wave = wv;
    @(posedge clk);
    model_edge(we, a, d, tk);
    #1;
    reg_we = 0; vf_tick = 0;
    check_pins();
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    step(1, a, d, 2'b00, vf_wave);
  endtask

  task automatic rd_chk(input logic [5:0] a, input string tag);
    logic [31:0] e;
    @(negedge clk);
    reg_addr = a;
    #1;
    e = exp_rd(a);
    check(reg_rdata == e, tag, reg_rdata, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int hi, lo;
    void'($urandom(32'd7321));
    for (int c = 0; c < 2; c++) begin
      m_mode[c] = 0; m_route[c] = 0; m_on[c] = 0; m_per[c] = 0;
      m_cwh[c] = 0; m_cwl[c] = 0; a_cnt[c] = 0; a_on[c] = 0; a_per[c] = 0;
    end
    rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0; vf_tick = 0; vf_wave = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);

    // R1: reset state
    for (int a = 0; a < 64; a += 4) rd_chk(6'(a), "R1");
    step(0, 0, 0, 2'b00, 2'b11);
    check(pin_oe == 2'b11 && pin_out == 2'b11, "R1", {pin_out, pin_oe}, 4'b1111);
    step(0, 0, 0, 2'b00, 2'b00);
    check(pin_oe == 2'b11 && pin_out == 2'b00, "R1", {pin_out, pin_oe}, 4'b0011);

    // R2: register map and read-back
    wr(6'h08, 32'hFFFF_FFA5); wr(6'h0C, 32'h3C); wr(6'h10, 32'h77); wr(6'h14, 32'h81);
    wr(6'h18, 32'h12); wr(6'h1C, 32'h34); wr(6'h20, 32'h56); wr(6'h24, 32'h78);
    wr(6'h04, 32'hFFFF_FFFF); wr(6'h00, 32'hFFFF_FFE6);
    for (int a = 0; a < 64; a += 4) rd_chk(6'(a), "R2");
    @(negedge clk); reg_addr = 6'h04; #1;
    check(reg_rdata == 32'h11, "R2", reg_rdata, 32'h11);
    @(negedge clk); reg_addr = 6'h2C; #1;
    check(reg_rdata == 32'h0, "R2", reg_rdata, 0);
    wr(6'h00, 0);

    // R3: ON=3 PERIOD=5 on channel 0
    wr(6'h18, 3); wr(6'h1C, 5); wr(6'h04, 32'h11); wr(6'h00, 32'h01);
    hi = 0;
    for (int i = 0; i < 6; i++) begin
      hi += pin_out[0];
      step(0, 0, 0, 2'b01, 2'b00);
    end
    check(hi == 3, "R3", hi, 3);
    check(pin_out[0] == 1, "R3", pin_out[0], 1);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 2'b00, 2'b00);
    check(pin_out[0] == 1, "R3", pin_out[0], 1);

    // R10: rewrite ON mid-period
    step(0, 0, 0, 2'b01, 2'b00); step(0, 0, 0, 2'b01, 2'b00);
    wr(6'h18, 0);
    rd_chk(6'h18, "R10");
    check(pin_out[0] == 1, "R10", pin_out[0], 1);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 2'b01, 2'b00);
    check(pin_out[0] == 0, "R10", pin_out[0], 0);
    step(0, 0, 0, 2'b01, 2'b00);
    check(pin_out[0] == 0, "R10", pin_out[0], 0);

    // R5: stop
    wr(6'h18, 3);
    wr(6'h00, 32'h00);
    check(pin_out[0] == 0 && pin_oe[0] == 1, "R5", pin_out[0], 0);

    // R4: 0xFF / 0xFE on channel 1
    wr(6'h20, 8'hFF); wr(6'h24, 8'hFE); wr(6'h00, 32'h10);
    lo = 0;
    for (int i = 0; i < 300; i++) begin
      step(0, 0, 0, 2'b10, 2'b00);
      lo += !pin_out[1];
    end
    check(lo == 0, "R4", lo, 0);
    wr(6'h00, 0); wr(6'h20, 9); wr(6'h24, 4); wr(6'h00, 32'h10);
    lo = 0;
    for (int i = 0; i < 20; i++) begin
      step(0, 0, 0, 2'b10, 2'b00);
      lo += !pin_out[1];
    end
    check(lo == 0, "R4", lo, 0);

    // R6: raw routing
    wr(6'h04, 32'h10); wr(6'h00, 32'h01);
    step(0, 0, 0, 2'b01, 2'b01);
    check(pin_out[0] == 1, "R6", pin_out[0], 1);
    step(0, 0, 0, 2'b01, 2'b00);
    check(pin_out[0] == 0, "R6", pin_out[0], 0);

    // R7 / R8 / R9 priorities
    wr(6'h04, 32'h11); wr(6'h00, 32'h04);
    check(pin_out[0] == 1 && pin_oe[0] == 1, "R7", {pin_out[0], pin_oe[0]}, 2'b11);
    wr(6'h00, 32'h06);
    check(pin_oe[0] == 0, "R8", pin_oe[0], 0);
    wr(6'h00, 32'h0E);
    check(pin_oe[0] == 0 && pin_out[0] == 0, "R8", {pin_out[0], pin_oe[0]}, 0);
    wr(6'h00, 32'h0C);
    check(pin_oe[0] == 0 && pin_out[0] == 0, "R9", {pin_out[0], pin_oe[0]}, 0);
    wr(6'h00, 32'h08);
    check(pin_oe[0] == 1 && pin_out[0] == 0, "R9", {pin_out[0], pin_oe[0]}, 1);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      logic [5:0]  a;
      logic [31:0] d;
      bit          we;
      we = ($urandom_range(0, 7) == 0);
      a  = 6'(4 * $urandom_range(0, 15));
      d  = $urandom;
      if (a >= 6'h18) d = ($urandom_range(0, 9) == 0) ? 32'hFF : 32'($urandom_range(0, 12));
      if (a == 6'h00 && $urandom_range(0, 3) != 0) d = (d & 32'h99) | 32'h11;
      step(we, a, d, 2'($urandom), 2'($urandom));
      if ($urandom_range(0, 31) == 0) rd_chk(6'(4 * $urandom_range(0, 15)), "R2");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule